// File: doc/BRIEF.md
# Dual-Edge Dead-Band Delay Generator

This block turns one or two PWM inputs into a complementary output pair with guard time between the two switches. It has two delay paths. The rising path holds its output low for a programmed number of clock ticks after its input goes high. The falling path holds its output high for a programmed number of ticks after its input goes low. Each path can take either PWM input. Each output can take either path and can be inverted after the delay. This is enough to build an active-high complementary pair with separate turn-on and turn-off guard times. It can also pass a signal straight through.

The control word and the two 14-bit delay values are written through a small register port into shadow registers. They are copied into the active registers together, only when the load strobe is high. Software can therefore stage a full new setup while the outputs run, and switch to it in one cycle.

Top module: `deadband_gen`

## Requirements
- R1: After reset the active control is 0x28 and both delays are 0, so `out_a` equals `pwm_a_in` and `out_b` equals the inverse of `pwm_a_in` in the same cycle.
- R2: With a rising delay D > 0, the rising path goes high on the D-th clock after the first cycle its input is sampled high, and goes low in the same cycle that its input goes low.
- R3: With a falling delay D > 0, the falling path goes low on the D-th clock after the first cycle its input is sampled low, and goes high in the same cycle that its input goes high.
- R4: A delay of 0 passes the path input through in the same cycle, with no register in the way.
- R5: An input pulse (rising path) or gap (falling path) that is shorter than the programmed delay leaves that path's output unchanged for its whole length.
- R6: `wr_en` writes a shadow register selected by `wr_addr`: 0 is control, 1 is the rising delay, 2 is the falling delay. Address 3 is ignored. Shadow writes do not change the outputs until a load.
- R7: When `load` is high at a clock edge, the three active registers take the shadow values held before that edge. A write in the same cycle only updates the shadow.
- R8: Control bit 0 selects the rising-path source and bit 1 selects the falling-path source (0 = `pwm_a_in`, 1 = `pwm_b_in`).
- R9: Control bit 2 selects the source for `out_a` and bit 3 selects the source for `out_b` (0 = rising path, 1 = falling path).
- R10: Control bit 4 inverts `out_a` and bit 5 inverts `out_b`. The inversion is applied after the path selection.
- R11: The delays are 14 bits wide. The largest value, 16383, delays the edge by exactly 16383 clocks, with no wrap of the counter.
- R12: While an input stays in its delayed level, a path's tick count stops at the active delay value. A load that raises the delay therefore counts on from that stopped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one delay tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_a_in | input | 1 | PWM input A |
| pwm_b_in | input | 1 | PWM input B |
| wr_en | input | 1 | Shadow register write enable |
| wr_addr | input | 2 | Shadow register select |
| wr_data | input | DATA_W (14) | Write data; the low 6 bits are used for control |
| load | input | 1 | Copy the shadow registers to the active registers |
| out_a | output | 1 | Output A after delay, selection and inversion |
| out_b | output | 1 | Output B after delay, selection and inversion |

## Verification
The bench targets pulses that are one tick shorter than the delay, exactly equal to it, and longer than it. An off-by-one counter would either let a runt pulse through or trim one cycle from every delayed edge. A zero delay must pass the edge through in the same cycle; a design with a register in that path would lag by one clock. A write in the same cycle as a load must not reach the active registers, and a shadow write without a load must leave the outputs unchanged; a design that loaded continuously, or forwarded the write, would switch setups early. The full 14-bit delay, and a load that changes the delay or the source while a count has stopped, show counter wrap or loss of the stopped count as outputs that toggle at the wrong time.

// File: rtl/dbgen_pkg.sv
package dbgen_pkg;

   localparam int CTRL_W = 6;

   // Field order sets the bit positions software writes (bit 0 = src_rise).
   typedef struct packed {
      logic inv_b;
      logic inv_a;
      logic route_b;
      logic route_a;
      logic src_fall;
      logic src_rise;
   } dbgen_ctrl_t;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_RISE = 2'd1;
   localparam logic [1:0] ADDR_FALL = 2'd2;

   // out_a = rising path of A, out_b = inverted falling path of A
   localparam dbgen_ctrl_t CTRL_RESET = '{inv_b: 1'b1, inv_a: 1'b0,
                                          route_b: 1'b1, route_a: 1'b0,
                                          src_fall: 1'b0, src_rise: 1'b0};

endpackage

// File: rtl/dbgen_regs.sv
module dbgen_regs
   import dbgen_pkg::*;
#(
   parameter int CNT_W  = 14,
   parameter int DATA_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              load,
   output dbgen_ctrl_t       act_ctrl,
   output logic [CNT_W-1:0]  act_rise,
   output logic [CNT_W-1:0]  act_fall
);

   dbgen_ctrl_t      sh_ctrl;
   logic [CNT_W-1:0] sh_rise;
   logic [CNT_W-1:0] sh_fall;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_ctrl <= CTRL_RESET;
         sh_rise <= '0;
         sh_fall <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            ADDR_CTRL: sh_ctrl <= dbgen_ctrl_t'(wr_data[CTRL_W-1:0]);
            ADDR_RISE: sh_rise <= wr_data[CNT_W-1:0];
            ADDR_FALL: sh_fall <= wr_data[CNT_W-1:0];
            default:   ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_ctrl <= CTRL_RESET;
         act_rise <= '0;
         act_fall <= '0;
      end else if (load) begin
         act_ctrl <= sh_ctrl;
         act_rise <= sh_rise;
         act_fall <= sh_fall;
      end
   end

   // R6: active setup only moves on a load
   a_r6_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(act_ctrl) && $stable(act_rise) && $stable(act_fall)));

   // R7: a load takes the shadow contents from before the edge
   a_r7_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (act_ctrl == $past(sh_ctrl) && act_rise == $past(sh_rise)
                && act_fall == $past(sh_fall)));

   // R6: address 3 leaves every shadow register alone
   a_r6_spare_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd3) |=> ($stable(sh_ctrl) && $stable(sh_rise) && $stable(sh_fall)));

endmodule

// File: rtl/dbgen_edge_delay.sv
module dbgen_edge_delay #(
   parameter int CNT_W      = 14,
   parameter bit DELAY_FALL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   input  logic [CNT_W-1:0] dly,
   output logic             dout
);

   // Work in a normalised domain where the delayed edge is always a rise.
   logic             x;
   logic             y;
   logic [CNT_W-1:0] cnt;

   generate
      if (DELAY_FALL) begin : g_fall
         assign x    = ~din;
         assign dout = ~y;
      end else begin : g_rise
         assign x    = din;
         assign dout = y;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt <= '0;
      else if (!x)       cnt <= '0;
      else if (cnt < dly) cnt <= cnt + 1'b1;
   end

   assign y = x && (cnt >= dly);

   // R2, R3: a delayed edge never appears in the first cycle of the level
   a_r2_r3_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (x && !$past(x) && dly != '0) |-> !y);

   // R4: zero delay is transparent
   a_r4_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (dly == '0) |-> (y == x));

   // R5: the delayed level only starts after the input level has lasted
   a_r5_no_runt: assert property (@(posedge clk) disable iff (!rst_n)
      (y && !$past(y) && dly != '0) |-> $past(x));

   // R11: the count never passes the all-ones value
   a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == {CNT_W{1'b1}}) |=> (cnt == {CNT_W{1'b1}} || cnt == '0 || cnt <= dly));

endmodule

// File: rtl/deadband_gen.sv
module deadband_gen
   import dbgen_pkg::*;
#(
   parameter int CNT_W  = 14,
   parameter int DATA_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwm_a_in,
   input  logic              pwm_b_in,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              load,
   output logic              out_a,
   output logic              out_b
);

   localparam int N_OUT = 2;

   generate
      if (DATA_W < CNT_W) begin : g_chk_cnt
         $error("deadband_gen: DATA_W must hold a full delay value");
      end
      if (DATA_W < CTRL_W) begin : g_chk_ctrl
         $error("deadband_gen: DATA_W must hold the control word");
      end
      if (CNT_W < 1) begin : g_chk_w
         $error("deadband_gen: CNT_W must be positive");
      end
   endgenerate

   dbgen_ctrl_t      ctrl;
   logic [CNT_W-1:0] dly_rise;
   logic [CNT_W-1:0] dly_fall;
   logic             rise_path;
   logic             fall_path;
   logic             rise_src;
   logic             fall_src;

   dbgen_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .load     (load),
      .act_ctrl (ctrl),
      .act_rise (dly_rise),
      .act_fall (dly_fall)
   );

   assign rise_src = ctrl.src_rise ? pwm_b_in : pwm_a_in;
   assign fall_src = ctrl.src_fall ? pwm_b_in : pwm_a_in;

   dbgen_edge_delay #(.CNT_W(CNT_W), .DELAY_FALL(1'b0)) u_rise (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rise_src),
      .dly  (dly_rise),
      .dout (rise_path)
   );

   dbgen_edge_delay #(.CNT_W(CNT_W), .DELAY_FALL(1'b1)) u_fall (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (fall_src),
      .dly  (dly_fall),
      .dout (fall_path)
   );

   logic [N_OUT-1:0] route_sel;
   logic [N_OUT-1:0] inv_sel;
   logic [N_OUT-1:0] outs;

   assign route_sel = {ctrl.route_b, ctrl.route_a};
   assign inv_sel   = {ctrl.inv_b, ctrl.inv_a};

   generate
      for (genvar ch = 0; ch < N_OUT; ch++) begin : g_out
         assign outs[ch] = (route_sel[ch] ? fall_path : rise_path) ^ inv_sel[ch];
      end
   endgenerate

   assign out_a = outs[0];
   assign out_b = outs[1];

endmodule

// File: tb/deadband_gen_tb.sv
module deadband_gen_tb;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 14;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          pwm_a_in, pwm_b_in, wr_en, load;
   logic [1:0]    wr_addr;
   logic [W-1:0]  wr_data;
   logic          out_a, out_b;

   int            n_checks = 0;
   int            n_errors = 0;
   string         cur_req  = "R1";

   // reference state
   logic [5:0]    m_sh_ctrl, m_ctrl;
   int            m_sh_red, m_sh_fed, m_red, m_fed;
   int            m_cr, m_cf;
   logic          cur_a = 1'b0, cur_b = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   deadband_gen u_dut (
      .clk(clk), .rst_n(rst_n), .pwm_a_in(pwm_a_in), .pwm_b_in(pwm_b_in),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .load(load),
      .out_a(out_a), .out_b(out_b)
   );

   task automatic check(input string req, input logic act, input logic exp, input string what);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_sh_ctrl = 6'h28; m_ctrl = 6'h28;
      m_sh_red = 0; m_sh_fed = 0; m_red = 0; m_fed = 0;
      m_cr = 0; m_cf = 0;
   endtask

   // One clock: drive at negedge, compare, advance the model across the posedge.
   task automatic step(input logic a, input logic b, input logic we,
                       input logic [1:0] ad, input int dt, input logic ld);
      logic pr, pf, rp, fp, ea, eb;
      @(negedge clk);
      pwm_a_in = a; pwm_b_in = b; wr_en = we; wr_addr = ad;
      wr_data = W'(dt); load = ld;
      cur_a = a; cur_b = b;
      #1;
      pr = m_ctrl[0] ? b : a;
      pf = m_ctrl[1] ? b : a;
      rp = pr && (m_cr >= m_red);
      fp = !(!pf && (m_cf >= m_fed));
      ea = (m_ctrl[2] ? fp : rp) ^ m_ctrl[4];
      eb = (m_ctrl[3] ? fp : rp) ^ m_ctrl[5];
      check(cur_req, out_a, ea, "out_a");
      check(cur_req, out_b, eb, "out_b");
      m_cr = pr  ? ((m_cr < m_red) ? m_cr + 1 : m_cr) : 0;
      m_cf = !pf ? ((m_cf < m_fed) ? m_cf + 1 : m_cf) : 0;
      if (ld) begin
         m_ctrl = m_sh_ctrl; m_red = m_sh_red; m_fed = m_sh_fed;
      end
      if (we) begin
         case (ad)
            2'd0: m_sh_ctrl = dt[5:0];
            2'd1: m_sh_red  = dt & 16'h3FFF;
            2'd2: m_sh_fed  = dt & 16'h3FFF;
            default: ;
         endcase
      end
   endtask

   task automatic hold(input logic a, input logic b, input int n);
      for (int i = 0; i < n; i++) step(a, b, 1'b0, 2'd0, 0, 1'b0);
   endtask

   task automatic wr(input logic [1:0] ad, input int dt);
      step(cur_a, cur_b, 1'b1, ad, dt, 1'b0);
   endtask

   task automatic ld();
      step(cur_a, cur_b, 1'b0, 2'd0, 0, 1'b1);
   endtask

   // count cycles from the input rise until out_a rises (R2/R11 direct check)
   task automatic measure_rise(input int expect_d, input string req);
      int seen;
      seen = -1;
      for (int i = 0; i <= expect_d + 2; i++) begin
         step(1'b1, cur_b, 1'b0, 2'd0, 0, 1'b0);
         if (out_a === 1'b1 && seen < 0) seen = i;
      end
      n_checks++;
      if (seen != expect_d) begin
         n_errors++;
         $display("FAIL %s rise latency: actual=%0d expected=%0d", req, seen, expect_d);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
      $finish;
   end

   initial begin
      rst_n = 1'b0; pwm_a_in = 1'b0; pwm_b_in = 1'b0;
      wr_en = 1'b0; wr_addr = 2'd0; wr_data = '0; load = 1'b0;
      model_reset();
      repeat (3) @(negedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1: reset routing: out_a = A, out_b = ~A, no delay
      cur_req = "R1";
      hold(1'b0, 1'b0, 2);
      hold(1'b1, 1'b0, 2);
      check("R1", out_a, 1'b1, "out_a follows A");
      check("R1", out_b, 1'b0, "out_b inverts A");
      hold(1'b0, 1'b1, 2);

      // R2: rising delay of 3
      cur_req = "R2";
      wr(2'd1, 3); wr(2'd2, 2); ld();
      hold(1'b0, 1'b0, 4);
      measure_rise(3, "R2");
      hold(1'b1, 1'b0, 3);
      hold(1'b0, 1'b0, 4);

      // R3: falling delay of 2 seen on out_b (inverted falling path)
      cur_req = "R3";
      hold(1'b1, 1'b0, 6);
      hold(1'b0, 1'b0, 1);
      check("R3", out_b, 1'b0, "out_b held in first low cycle");
      hold(1'b0, 1'b0, 1);
      check("R3", out_b, 1'b0, "out_b held in second low cycle");
      hold(1'b0, 1'b0, 1);
      check("R3", out_b, 1'b1, "out_b high after fall delay");
      hold(1'b0, 1'b0, 3);

      // R5: runts shorter than the delay, then exactly equal
      cur_req = "R5";
      hold(1'b1, 1'b0, 2);
      check("R5", out_a, 1'b0, "runt pulse suppressed");
      hold(1'b0, 1'b0, 4);
      hold(1'b1, 1'b0, 3);
      hold(1'b0, 1'b0, 1);
      hold(1'b1, 1'b0, 4);
      hold(1'b0, 1'b0, 1);
      check("R5", out_b, 1'b0, "one-cycle gap suppressed on out_b");
      hold(1'b0, 1'b0, 4);

      // R6: shadow writes without load, and a write to the spare address
      cur_req = "R6";
      wr(2'd1, 7); wr(2'd3, 16'h3FFF);
      measure_rise(3, "R6");
      hold(1'b0, 1'b0, 4);

      // R7: load with a same-cycle write: shadow 7 goes active, 1 stays in shadow
      cur_req = "R7";
      step(1'b0, 1'b0, 1'b1, 2'd1, 1, 1'b1);
      hold(1'b0, 1'b0, 2);
      measure_rise(7, "R7");
      hold(1'b0, 1'b0, 4);
      ld();
      measure_rise(1, "R7");
      hold(1'b0, 1'b0, 3);

      // R4: zero delays pass straight through
      cur_req = "R4";
      wr(2'd1, 0); wr(2'd2, 0); ld();
      for (int i = 0; i < 12; i++) step(i[0], i[1], 1'b0, 2'd0, 0, 1'b0);
      hold(1'b1, 1'b0, 1);
      check("R4", out_a, 1'b1, "zero delay same cycle");

      // R8: both paths take B
      cur_req = "R8";
      hold(1'b0, 1'b0, 3);
      wr(2'd0, 6'h2B); wr(2'd1, 2); wr(2'd2, 3); ld();
      hold(1'b0, 1'b0, 5);
      for (int i = 0; i < 40; i++) step(i[2], i[3] ^ i[0], 1'b0, 2'd0, 0, 1'b0);
      hold(1'b0, 1'b0, 5);

      // R9: out_a from falling path, out_b from rising path
      cur_req = "R9";
      wr(2'd0, 6'h04); ld();
      hold(1'b0, 1'b0, 5);
      for (int i = 0; i < 40; i++) step(i[3] | i[1], i[0], 1'b0, 2'd0, 0, 1'b0);
      hold(1'b0, 1'b0, 5);

      // R10: invert out_a, leave out_b plain falling path
      cur_req = "R10";
      wr(2'd0, 6'h18); ld();
      hold(1'b0, 1'b0, 5);
      check("R10", out_a, 1'b1, "inverted idle out_a");
      for (int i = 0; i < 40; i++) step(i[2] & i[0], 1'b0, 1'b0, 2'd0, 0, 1'b0);
      hold(1'b0, 1'b0, 5);

      // R12: raise the delay while a count has stopped at the old value
      cur_req = "R12";
      wr(2'd0, 6'h28); wr(2'd1, 2); ld();
      hold(1'b1, 1'b0, 5);
      wr(2'd1, 6); ld();
      hold(1'b1, 1'b0, 1);
      check("R12", out_a, 1'b0, "out_a drops while count resumes");
      hold(1'b1, 1'b0, 5);
      hold(1'b0, 1'b0, 3);

      // R11: full-width delay
      cur_req = "R11";
      wr(2'd1, 16383); ld();
      hold(1'b0, 1'b0, 2);
      measure_rise(16383, "R11");
      hold(1'b0, 1'b0, 3);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule